// File: doc/BRIEF.md
# Display link sideband request framer with bounded retry

This block turns a single transfer request into a sideband request packet for a display link. The request can be a native read, a native write, or a single-byte I2C-tunnelled read or write. It hands the packet to a lower channel engine through a valid/response handshake and reads the status and reply code that come back. From these it decides whether to finish, resend at once, wait and resend, or give up. When it ends, it reports one result code with the received data.

The channel engine is outside the block. It takes a 32-bit header, a total message length and the write payload. It answers with a 2-bit channel status, a 4-bit reply code, a received-byte count and the received bytes. Wait times are counted in clock cycles: `CLK_PER_US` cycles make one microsecond. The requester sees a ready flag, and each transfer ends with a one-cycle done pulse.

Top module: `aux_req_framer`

## Requirements
- R1: The header sent on `ch_hdr` packs four bytes with byte 0 in bits 7:0. Byte 0 is the address low byte and byte 1 is the address high byte. Byte 2 carries the command in its upper nibble and zero in its lower nibble. Byte 3 carries the low four bits of the total message length in its upper nibble. Its lower nibble is the payload length minus one for native transfers and zero for I2C transfers.
- R2: `ch_msg_len` is the payload length plus 4 for a native write, 4 for a native read, 5 for an I2C write and 4 for an I2C read.
- R3: A native request (kind 0 = write, kind 1 = read) with length 0 or above `MAX_PAYLOAD` is rejected with code 5 on the next cycle. No channel request is made.
- R4: A transfer is sent at most `MAX_TRIES` (4) times. When a retry is due after the last attempt, the block ends with code 2 (I/O error).
- R5: Channel status 1 ends the transfer with code 1 (timeout). Status 3 ends it with code 2. Status 2 (busy) resends within two cycles and does not wait.
- R6: For native kinds the reply field is `ch_reply[1:0]`. 00 (ACK) ends with code 0. 10 (DEFER) waits `DEFER_US` microseconds and then resends. 01 and 11 end with code 2.
- R7: A native read whose reply is neither ACK nor DEFER and whose received count is 0 ends with code 3 (protocol error) instead of code 2.
- R8: The commands are 8 for a native write and 9 for a native read. For I2C the command is 0 for a write and 1 for a read. When `req_stop` is low, 4 is added to the I2C command (the middle-of-transaction flag).
- R9: For I2C kinds (2 = write, 3 = read), `ch_reply[3:2]` is examined only when `ch_reply[1:0]` is ACK. In that field, 00 ends with code 0, 10 waits and resends, and 01 or 11 end with code 4. A DEFER in `ch_reply[1:0]` waits and resends. Any other value in `ch_reply[1:0]` ends with code 4.
- R10: On success the count is the requested length for a native write and 1 for an I2C write. For a native read it is the received count clamped to the requested length, and for an I2C read it is the received count clamped to 1. `rsp_data` holds the received bytes below that count for reads and is zero in every other byte and on every non-success.
- R11: `rsp_done` is a one-cycle pulse. `req_ready` is high only while the block is idle and not pulsing done, and a request presented while `req_ready` is low is ignored.
- R12: After reset, `req_ready` is high and `ch_req_valid` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 0 native write, 1 native read, 2 I2C write, 3 I2C read |
| req_stop | input | 1 | I2C transfer ends with a stop |
| req_addr | input | 16 | Target address |
| req_len | input | CNT_W | Native payload length or read buffer size |
| req_wdata | input | DATA_W | Write payload, byte 0 in bits 7:0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 protocol, 4 remote error, 5 bad length |
| rsp_count | output | CNT_W | Bytes transferred |
| rsp_data | output | DATA_W | Received bytes |
| ch_req_valid | output | 1 | Request to channel engine, held until response |
| ch_hdr | output | 32 | Packet header |
| ch_msg_len | output | MLEN_W | Total message length in bytes |
| ch_payload | output | DATA_W | Write payload to channel |
| ch_rsp_valid | input | 1 | Channel response strobe |
| ch_status | input | 2 | 0 done, 1 timeout, 2 busy, 3 error |
| ch_reply | input | 4 | Reply code: native field 1:0, I2C field 3:2 |
| ch_rx_count | input | CNT_W | Bytes received |
| ch_rx_data | input | DATA_W | Received bytes |

## Verification
The bench builds the block with `CLK_PER_US` = 2, `MAX_PAYLOAD` = 16 and `MAX_TRIES` = 4. With these values a defer wait is 800 cycles, so several defers fit in a short run and the gap before a resend can be measured exactly. A 16-byte write, whose header length nibble wraps, and a 17-byte write that must be rejected both become reachable. With four tries, runs of busy and defer replies show both the exhaustion path and recovery on a later attempt.

// File: rtl/aux_fr_pkg.sv
package aux_fr_pkg;
  // request kinds: bit1 = I2C tunnelled, bit0 = read
  localparam logic [1:0] K_NWR = 2'd0;
  localparam logic [1:0] K_NRD = 2'd1;
  localparam logic [1:0] K_IWR = 2'd2;
  localparam logic [1:0] K_IRD = 2'd3;

  // result codes
  localparam logic [2:0] RC_OK      = 3'd0;
  localparam logic [2:0] RC_TIMEOUT = 3'd1;
  localparam logic [2:0] RC_IOERR   = 3'd2;
  localparam logic [2:0] RC_PROTO   = 3'd3;
  localparam logic [2:0] RC_REMOTE  = 3'd4;
  localparam logic [2:0] RC_BADLEN  = 3'd5;

  // channel status
  localparam logic [1:0] CS_TIMEOUT = 2'd1;
  localparam logic [1:0] CS_BUSY    = 2'd2;
  localparam logic [1:0] CS_ERROR   = 2'd3;

  // reply field values
  localparam logic [1:0] RP_ACK   = 2'd0;
  localparam logic [1:0] RP_DEFER = 2'd2;

  // command nibbles
  localparam logic [3:0] CMD_NWR = 4'h8;
  localparam logic [3:0] CMD_NRD = 4'h9;
  localparam logic [3:0] CMD_IWR = 4'h0;
  localparam logic [3:0] CMD_IRD = 4'h1;
  localparam logic [3:0] CMD_MOT = 4'h4;

  // decoder verdicts
  typedef enum logic [1:0] {ACT_DONE, ACT_FAIL, ACT_RESEND, ACT_WAIT} act_e;
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
  import aux_fr_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int MLEN_W = 5
) (
  input  logic [1:0]        kind,
  input  logic              stop,
  input  logic [15:0]       addr,
  input  logic [CNT_W-1:0]  len,
  output logic [31:0]       hdr,
  output logic [MLEN_W-1:0] msg_len
);
  logic [3:0] cmd;
  logic [7:0] total;
  logic [7:0] len_m1;

  always_comb begin
    cmd    = CMD_NWR;
    total  = 8'(len) + 8'd4;
    len_m1 = 8'(len) - 8'd1;
    case (kind)
      K_NWR: begin
        cmd   = CMD_NWR;
        total = 8'(len) + 8'd4;
      end
      K_NRD: begin
        cmd   = CMD_NRD;
        total = 8'd4;
      end
      K_IWR: begin
        cmd    = stop ? CMD_IWR : (CMD_IWR | CMD_MOT);
        total  = 8'd5;
        len_m1 = 8'd0;
      end
      default: begin
        cmd    = stop ? CMD_IRD : (CMD_IRD | CMD_MOT);
        total  = 8'd4;
        len_m1 = 8'd0;
      end
    endcase
    hdr     = {total[3:0], len_m1[3:0], cmd, 4'h0, addr[15:8], addr[7:0]};
    msg_len = MLEN_W'(total);
  end
endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_fr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [1:0]       kind,
  input  logic [1:0]       status,
  input  logic [3:0]       reply,
  input  logic [CNT_W-1:0] rx_count,
  output act_e             act,
  output logic [2:0]       code
);
  logic [1:0] nat_f;
  logic [1:0] i2c_f;
  assign nat_f = reply[1:0];
  assign i2c_f = reply[3:2];

  always_comb begin
    act  = ACT_FAIL;
    code = RC_IOERR;
    case (status)
      CS_TIMEOUT: begin act = ACT_FAIL; code = RC_TIMEOUT; end
      CS_BUSY:    begin act = ACT_RESEND; code = RC_IOERR; end
      CS_ERROR:   begin act = ACT_FAIL; code = RC_IOERR; end
      default: begin
        if (!kind[1]) begin
          if (nat_f == RP_ACK) begin
            act = ACT_DONE; code = RC_OK;
          end else if (nat_f == RP_DEFER) begin
            act = ACT_WAIT;
          end else begin
            act  = ACT_FAIL;
            code = (kind == K_NRD && rx_count == '0) ? RC_PROTO : RC_IOERR;
          end
        end else begin
          if (nat_f == RP_ACK) begin
            if (i2c_f == RP_ACK) begin
              act = ACT_DONE; code = RC_OK;
            end else if (i2c_f == RP_DEFER) begin
              act = ACT_WAIT;
            end else begin
              act = ACT_FAIL; code = RC_REMOTE;
            end
          end else if (nat_f == RP_DEFER) begin
            act = ACT_WAIT;
          end else begin
            act = ACT_FAIL; code = RC_REMOTE;
          end
        end
      end
    endcase
  end

  always_comb begin
    if (act == ACT_FAIL) AST_FAIL_HAS_CODE: assert (code != RC_OK); // R5
  end
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int LIMIT = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  logic          running;

  assign done = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= CW'(LIMIT - 1);
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  AST_TIMER_NO_RESTART: assert property (@(posedge clk) disable iff (rst) start |-> !running); // R6
  AST_TIMER_ONE_SHOT: assert property (@(posedge clk) disable iff (rst) done && !start |=> !running); // R6
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_fr_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int MAX_TRIES   = 4,
  parameter int CLK_PER_US  = 100,
  parameter int DEFER_US    = 400,
  localparam int DATA_W     = MAX_PAYLOAD * 8,
  localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1),
  localparam int MLEN_W     = $clog2(MAX_PAYLOAD + 5)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_stop,
  input  logic [15:0]       req_addr,
  input  logic [CNT_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [2:0]        rsp_code,
  output logic [CNT_W-1:0]  rsp_count,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ch_req_valid,
  output logic [31:0]       ch_hdr,
  output logic [MLEN_W-1:0] ch_msg_len,
  output logic [DATA_W-1:0] ch_payload,
  input  logic              ch_rsp_valid,
  input  logic [1:0]        ch_status,
  input  logic [3:0]        ch_reply,
  input  logic [CNT_W-1:0]  ch_rx_count,
  input  logic [DATA_W-1:0] ch_rx_data
);
  localparam int WAIT_CYC = CLK_PER_US * DEFER_US;
  localparam int ATT_W    = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0] MAX_LEN  = CNT_W'(MAX_PAYLOAD);
  localparam logic [ATT_W-1:0] LAST_ATT = ATT_W'(MAX_TRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP, S_WAIT} st_e;
  st_e st;

  logic [1:0]        kind_q;
  logic [CNT_W-1:0]  len_q;
  logic [ATT_W-1:0]  att;
  logic [31:0]       hdr_d;
  logic [MLEN_W-1:0] mlen_d;

  // header formed from the incoming request, captured on accept
  aux_hdr_build #(.CNT_W(CNT_W), .MLEN_W(MLEN_W)) hdr_i (
    .kind(req_kind), .stop(req_stop), .addr(req_addr), .len(req_len),
    .hdr(hdr_d), .msg_len(mlen_d)
  );

  act_e       act;
  logic [2:0] dec_code;
  aux_reply_decode #(.CNT_W(CNT_W)) dec_i (
    .kind(kind_q), .status(ch_status), .reply(ch_reply), .rx_count(ch_rx_count),
    .act(act), .code(dec_code)
  );

  logic fin, resend_go, tmr_start, tmr_done;
  logic [2:0]        fin_code;
  logic [CNT_W-1:0]  ok_cnt;
  logic [DATA_W-1:0] rd_masked;

  aux_wait_timer #(.LIMIT(WAIT_CYC)) tmr_i (
    .clk(clk), .rst(rst), .start(tmr_start), .done(tmr_done)
  );

  logic bad_len;
  assign bad_len   = !req_kind[1] && (req_len == '0 || req_len > MAX_LEN);
  assign req_ready = (st == S_IDLE) && !rsp_done;
  assign ch_req_valid = (st == S_SEND);

  // byte count reported on success, clamped to the requester's buffer
  always_comb begin
    case (kind_q)
      K_NWR:   ok_cnt = len_q;
      K_NRD:   ok_cnt = (ch_rx_count < len_q) ? ch_rx_count : len_q;
      K_IWR:   ok_cnt = CNT_W'(1);
      default: ok_cnt = (ch_rx_count != '0) ? CNT_W'(1) : '0;
    endcase
  end

  for (genvar b = 0; b < MAX_PAYLOAD; b++) begin : g_mask
    assign rd_masked[b*8 +: 8] = (CNT_W'(b) < ok_cnt) ? ch_rx_data[b*8 +: 8] : 8'h00;
  end

  always_comb begin
    fin       = 1'b0;
    fin_code  = RC_IOERR;
    resend_go = 1'b0;
    if (st == S_SEND && ch_rsp_valid) begin
      case (act)
        ACT_DONE: begin fin = 1'b1; fin_code = RC_OK; end
        ACT_FAIL: begin fin = 1'b1; fin_code = dec_code; end
        default: begin
          if (att == LAST_ATT) begin fin = 1'b1; fin_code = RC_IOERR; end
          else resend_go = 1'b1;
        end
      endcase
    end
  end
  assign tmr_start = resend_go && (act == ACT_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind_q     <= '0;
      len_q      <= '0;
      att        <= '0;
      ch_hdr     <= '0;
      ch_msg_len <= '0;
      ch_payload <= '0;
      rsp_done   <= 1'b0;
      rsp_code   <= RC_OK;
      rsp_count  <= '0;
      rsp_data   <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            if (bad_len) begin
              rsp_done  <= 1'b1;
              rsp_code  <= RC_BADLEN;
              rsp_count <= '0;
              rsp_data  <= '0;
            end else begin
              kind_q     <= req_kind;
              len_q      <= req_len;
              ch_hdr     <= hdr_d;
              ch_msg_len <= mlen_d;
              ch_payload <= req_wdata;
              att        <= '0;
              st         <= S_SEND;
            end
          end
        end
        S_SEND: begin
          if (fin) begin
            rsp_done  <= 1'b1;
            rsp_code  <= fin_code;
            rsp_count <= (fin_code == RC_OK) ? ok_cnt : '0;
            rsp_data  <= (fin_code == RC_OK && kind_q[0]) ? rd_masked : '0;
            st        <= S_IDLE;
          end else if (resend_go) begin
            att <= att + 1'b1;
            st  <= (act == ACT_WAIT) ? S_WAIT : S_GAP;
          end
        end
        S_GAP:   st <= S_SEND;
        default: if (tmr_done) st <= S_SEND;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> ($past(ch_rsp_valid) || $past(req_valid))); // R11
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst) ch_req_valid |-> !req_ready); // R11
  AST_BADLEN_NO_CHAN: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_code == RC_BADLEN) |-> !$past(ch_req_valid)); // R3
  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_code == RC_OK && !kind_q[1]) |-> rsp_count <= len_q); // R10
endmodule

// File: tb/aux_req_framer_tb_top.sv
`timescale 1ns/1ps
module aux_req_framer_tb_top;
  localparam int MAXP = 16;
  localparam int DW   = MAXP * 8;
  localparam int CW   = $clog2(MAXP + 1);
  localparam int MW   = $clog2(MAXP + 5);
  localparam int CPU  = 2;
  localparam int DEFER_CYC = CPU * 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready, req_stop = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [15:0]   req_addr = '0;
  logic [CW-1:0] req_len = '0;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [2:0]    rsp_code;
  logic [CW-1:0] rsp_count;
  logic [DW-1:0] rsp_data;
  logic          ch_req_valid;
  logic [31:0]   ch_hdr;
  logic [MW-1:0] ch_msg_len;
  logic [DW-1:0] ch_payload;
  logic          ch_rsp_valid = 1'b0;
  logic [1:0]    ch_status = '0;
  logic [3:0]    ch_reply = '0;
  logic [CW-1:0] ch_rx_count = '0;
  logic [DW-1:0] ch_rx_data;

  aux_req_framer #(.MAX_PAYLOAD(MAXP), .MAX_TRIES(4), .CLK_PER_US(CPU), .DEFER_US(400)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_stop(req_stop), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_code(rsp_code),
    .rsp_count(rsp_count), .rsp_data(rsp_data), .ch_req_valid(ch_req_valid),
    .ch_hdr(ch_hdr), .ch_msg_len(ch_msg_len), .ch_payload(ch_payload),
    .ch_rsp_valid(ch_rsp_valid), .ch_status(ch_status), .ch_reply(ch_reply),
    .ch_rx_count(ch_rx_count), .ch_rx_data(ch_rx_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        stop;
    logic [15:0] addr;
    logic [4:0]  len;
    logic [7:0]  st;   // status per attempt, attempt 0 in bits 1:0
    logic [15:0] rp;   // reply nibble per attempt, attempt 0 in bits 3:0
    logic [4:0]  rx;
    logic [2:0]  ecode;
    logic [4:0]  ecnt;
    logic [2:0]  eatt;
    logic [1:0]  gapk; // 0 none, 1 defer wait, 2 immediate resend
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,16'h0102,5'd2 ,8'h00,16'h0000,5'd0,3'd0,5'd2 ,3'd1,2'd0},
    '{2'd1,1'b0,16'h0200,5'd4 ,8'h00,16'h0000,5'd6,3'd0,5'd4 ,3'd1,2'd0},
    '{2'd1,1'b0,16'h0000,5'd8 ,8'h00,16'h0000,5'd3,3'd0,5'd3 ,3'd1,2'd0},
    '{2'd0,1'b0,16'h0103,5'd1 ,8'h0A,16'h0000,5'd0,3'd0,5'd1 ,3'd3,2'd2},
    '{2'd1,1'b0,16'h0202,5'd2 ,8'h00,16'h0002,5'd2,3'd0,5'd2 ,3'd2,2'd1},
    '{2'd0,1'b0,16'h0100,5'd1 ,8'hAA,16'h0000,5'd0,3'd2,5'd0 ,3'd4,2'd2},
    '{2'd0,1'b0,16'h0101,5'd1 ,8'h01,16'h0000,5'd0,3'd1,5'd0 ,3'd1,2'd0},
    '{2'd1,1'b0,16'h0101,5'd1 ,8'h03,16'h0000,5'd0,3'd2,5'd0 ,3'd1,2'd0},
    '{2'd1,1'b0,16'h0600,5'd1 ,8'h00,16'h0001,5'd0,3'd3,5'd0 ,3'd1,2'd0},
    '{2'd1,1'b0,16'h0600,5'd2 ,8'h00,16'h0001,5'd2,3'd2,5'd0 ,3'd1,2'd0},
    '{2'd0,1'b0,16'h0600,5'd3 ,8'h00,16'h0003,5'd0,3'd2,5'd0 ,3'd1,2'd0},
    '{2'd3,1'b1,16'h0050,5'd0 ,8'h00,16'h0000,5'd1,3'd0,5'd1 ,3'd1,2'd0},
    '{2'd2,1'b0,16'h0050,5'd0 ,8'h00,16'h0000,5'd0,3'd0,5'd1 ,3'd1,2'd0},
    '{2'd3,1'b1,16'h0050,5'd0 ,8'h00,16'h0004,5'd1,3'd4,5'd0 ,3'd1,2'd0},
    '{2'd3,1'b0,16'h0050,5'd0 ,8'h00,16'h0008,5'd1,3'd0,5'd1 ,3'd2,2'd1},
    '{2'd2,1'b1,16'h0050,5'd0 ,8'h00,16'h0001,5'd0,3'd4,5'd0 ,3'd1,2'd0},
    '{2'd0,1'b0,16'h0104,5'd1 ,8'h00,16'h2222,5'd0,3'd2,5'd0 ,3'd4,2'd1},
    '{2'd0,1'b0,16'h0300,5'd16,8'h00,16'h0000,5'd0,3'd0,5'd16,3'd1,2'd0},
    '{2'd3,1'b1,16'h0050,5'd0 ,8'h00,16'h0003,5'd1,3'd4,5'd0 ,3'd1,2'd0},
    '{2'd2,1'b1,16'h0050,5'd0 ,8'h00,16'h000C,5'd0,3'd4,5'd0 ,3'd1,2'd0},
    '{2'd3,1'b1,16'h0050,5'd0 ,8'h00,16'h0006,5'd1,3'd0,5'd1 ,3'd2,2'd1}
  };

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // channel engine model
  vec_t        cur;
  int          att_i = 0;
  int          rsp_cyc = 0;
  int          gap1 = -1;
  logic [31:0] hdr0;
  logic [MW-1:0] mlen0;

  initial begin
    for (int i = 0; i < MAXP; i++) begin
      ch_rx_data[i*8 +: 8] = 8'hA0 + 8'(i);
      req_wdata[i*8 +: 8]  = 8'h10 + 8'(i);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (ch_rsp_valid) begin
        ch_rsp_valid = 1'b0;
        rsp_cyc = cyc;
      end else if (ch_req_valid) begin
        int k;
        k = (att_i > 3) ? 3 : att_i;
        if (att_i == 0) begin hdr0 = ch_hdr; mlen0 = ch_msg_len; end
        if (att_i == 1) gap1 = cyc - rsp_cyc;
        ch_status    = cur.st[2*k +: 2];
        ch_reply     = cur.rp[4*k +: 4];
        ch_rx_count  = CW'(cur.rx);
        ch_rsp_valid = 1'b1;
        att_i++;
      end
    end
  end

  function automatic logic [31:0] exp_hdr(vec_t v);
    logic [3:0] cmd;
    logic [7:0] tot;
    logic [7:0] lo;
    case (v.kind)
      2'd0: begin cmd = 4'h8; tot = 8'(v.len) + 8'd4; lo = 8'(v.len) - 8'd1; end
      2'd1: begin cmd = 4'h9; tot = 8'd4; lo = 8'(v.len) - 8'd1; end
      2'd2: begin cmd = v.stop ? 4'h0 : 4'h4; tot = 8'd5; lo = 8'd0; end
      default: begin cmd = v.stop ? 4'h1 : 4'h5; tot = 8'd4; lo = 8'd0; end
    endcase
    return {tot[3:0], lo[3:0], cmd, 4'h0, v.addr};
  endfunction

  function automatic logic [MW-1:0] exp_mlen(vec_t v);
    case (v.kind)
      2'd0: return MW'(v.len + 5'd4);
      2'd2: return MW'(5);
      default: return MW'(4);
    endcase
  endfunction

  function automatic string code_tag(vec_t v);
    if (v.kind[1])          return "R9";
    if (v.ecode == 3'd3)    return "R7";
    if (v.eatt == 3'd4)     return "R4";
    if (v.st[1:0] != 2'd0)  return "R5";
    return "R6";
  endfunction

  task automatic wait_done(output bit seen);
    int n = 0;
    while (!rsp_done && n < 5000) begin @(negedge clk); n++; end
    seen = rsp_done;
  endtask

  task automatic run_vec(input vec_t v, input bit inject);
    bit seen;
    logic [DW-1:0] exp_d;
    @(negedge clk);
    cur = v; att_i = 0; gap1 = -1;
    req_kind = v.kind; req_stop = v.stop; req_addr = v.addr; req_len = CW'(v.len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (20) @(negedge clk);
      chk(req_ready == 1'b0, "R11", "ready while busy", DW'(req_ready), DW'(0));
      req_kind = 2'd0; req_addr = 16'hFFFF; req_len = CW'(1); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_done(seen);
    chk(seen, "R11", "done seen", DW'(seen), DW'(1));
    exp_d = '0;
    if (v.ecode == 3'd0 && v.kind[0])
      for (int i = 0; i < MAXP; i++)
        if (i < int'(v.ecnt)) exp_d[i*8 +: 8] = 8'hA0 + 8'(i);
    chk(rsp_code == v.ecode, code_tag(v), "code", DW'(rsp_code), DW'(v.ecode));
    chk(rsp_count == CW'(v.ecnt), "R10", "count", DW'(rsp_count), DW'(v.ecnt));
    chk(rsp_data == exp_d, "R10", "data", rsp_data, exp_d);
    chk(att_i == int'(v.eatt), "R4", "attempts", DW'(att_i), DW'(v.eatt));
    chk(hdr0 == exp_hdr(v), v.kind[1] ? "R8" : "R1", "header", DW'(hdr0), DW'(exp_hdr(v)));
    chk(mlen0 == exp_mlen(v), "R2", "msg len", DW'(mlen0), DW'(exp_mlen(v)));
    if (v.gapk == 2'd1)
      chk(gap1 >= DEFER_CYC && gap1 <= DEFER_CYC + 1, "R6", "defer gap", DW'(gap1), DW'(DEFER_CYC));
    if (v.gapk == 2'd2)
      chk(gap1 >= 1 && gap1 <= 2, "R5", "busy gap", DW'(gap1), DW'(1));
    @(negedge clk);
    chk(rsp_done == 1'b0, "R11", "done width", DW'(rsp_done), DW'(0));
    if (inject) begin
      bit extra = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (rsp_done || ch_req_valid) extra = 1'b1;
      end
      chk(!extra, "R11", "ignored request", DW'(extra), DW'(0));
    end
  endtask

  task automatic bad_req(input logic [1:0] kind, input logic [CW-1:0] len);
    @(negedge clk);
    att_i = 0;
    req_kind = kind; req_len = len; req_addr = 16'h0123; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done == 1'b1 && rsp_code == 3'd5, "R3", "reject", DW'(rsp_code), DW'(5));
    repeat (3) @(negedge clk);
    chk(att_i == 0, "R3", "no channel request", DW'(att_i), DW'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready after reset", DW'(req_ready), DW'(1));
    chk(ch_req_valid == 1'b0, "R12", "channel idle after reset", DW'(ch_req_valid), DW'(0));
    chk(rsp_done == 1'b0, "R12", "done low after reset", DW'(rsp_done), DW'(0));
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    bad_req(2'd0, CW'(17));
    bad_req(2'd1, CW'(0));
    run_vec(VECS[4], 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule